// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block sets the instruction-cycle timing and fetch control for a small microcontroller core with separate program and data memories. It splits every instruction cycle into four oscillator periods and shows the current period on a one-hot phase bus. It keeps a program counter that drives the program-memory address. The 14-bit word at that address is latched into the instruction register at the close of each cycle.

Fetch and execute overlap. While the decoder works on the word in the instruction register, the next word is being addressed. When the executing instruction writes the program counter, the word fetched behind it is discarded. A no-operation is executed in its place, so any jump, call or return takes two instruction cycles.

A small circular stack keeps return addresses for call and return. When the stack is full, a further push overwrites the oldest entry, and no error is raised. The decoder reports branch, call and return on three strobes, with a shared target bus. The block acts on these strobes only on the last phase of a cycle, and only while the instruction register holds a valid word.

Top module: `fetch_seq`

## Requirements
- R1: The `phase` output is one-hot. Bit 0 is the first phase. The set bit moves up one position per clock and returns from bit `PHASES-1` (bit 3 by default) to bit 0, so one instruction cycle lasts four clocks.
- R2: While `mclrN` is low (asynchronous, active-low) the outputs are held as follows: `pmAddr` = 0, `instrReg` = 0, `execValid` = 0 and `phase` = 4'b0001. The return stack is emptied.
- R3: `pmAddr` and `instrReg` change only on the clock edge that ends the last phase. At that edge, if no program-counter write takes place, `instrReg` takes the word at `pmAddr`, `pmAddr` increases by one and `execValid` becomes 1.
- R4: A taken branch loads `pmAddr` with `brTarget`, clears `instrReg` to 14'h0000 (the no-operation) and clears `execValid` for one instruction cycle.
- R5: A call pushes the current `pmAddr` (the address after the call) onto the return stack and then behaves like a taken branch to `brTarget`.
- R6: A return loads `pmAddr` with the most recently pushed address, pops it from the stack, and then flushes as in R4.
- R7: When several strobes are high at the same time, return wins over call, and call wins over branch.
- R8: Strobes have no effect while `execValid` is 0, that is, during a flushed slot.
- R9: Strobes are sampled only on the last phase. A strobe that is high only in the earlier phases has no effect.
- R10: The stack pointer wraps modulo `STACK_DEPTH`. With a depth of N, a push made when N entries are already held overwrites the oldest entry. Later returns then read the entries again in circular order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| mclrN | input | 1 | Active-low master clear, asynchronous |
| brStrobe | input | 1 | Decoded jump request |
| callStrobe | input | 1 | Decoded call request |
| retStrobe | input | 1 | Decoded return request |
| brTarget | input | PC_W (13) | Target for jump and call |
| pmData | input | INSN_W (14) | Word read from program memory |
| pmAddr | output | PC_W (13) | Program-memory address (program counter) |
| instrReg | output | INSN_W (14) | Instruction register |
| phase | output | PHASES (4) | One-hot phase of the instruction cycle |
| execValid | output | 1 | Instruction register holds an instruction to execute |

## Verification
The bench builds the block with `STACK_DEPTH` = 4 and keeps the 13-bit counter and the four phases at their defaults. The smaller stack lets a short run make five nested calls and then five returns. This exercises the overwrite of the oldest entry and the circular re-reading of entries. Separate cases cover simultaneous strobes, strobes raised during a bubble, and a strobe dropped before the last phase.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  // Per-cycle decision made by the control unit, consumed by the datapath
  typedef struct packed {
    logic cycEnd;    // this clock closes the instruction cycle
    logic advance;   // sequential fetch
    logic doBranch;  // load target, flush
    logic doCall;    // push, load target, flush
    logic doRet;     // pop into PC, flush
  } seqCtl_t;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic              clk,
  input  logic              mclrN,
  input  logic              brStrobe,
  input  logic              callStrobe,
  input  logic              retStrobe,
  output seqCtl_t           ctl,
  output logic [PHASES-1:0] phase,
  output logic              execValid
);
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [PH_W-1:0] phaseCnt;
  logic            lastPhase;
  logic            pcWrite;

  assign lastPhase = (phaseCnt == LAST_PH);

  always_comb begin
    ctl        = '0;
    ctl.cycEnd = lastPhase;
    if (lastPhase) begin
      if (execValid && retStrobe)       ctl.doRet    = 1'b1;
      else if (execValid && callStrobe) ctl.doCall   = 1'b1;
      else if (execValid && brStrobe)   ctl.doBranch = 1'b1;
      else                              ctl.advance  = 1'b1;
    end
  end

  assign pcWrite = ctl.doRet | ctl.doCall | ctl.doBranch;

  always_ff @(posedge clk or negedge mclrN) begin
    if (!mclrN) begin
      phaseCnt  <= '0;
      execValid <= 1'b0;
    end else begin
      phaseCnt <= lastPhase ? '0 : phaseCnt + 1'b1;
      if (lastPhase) execValid <= !pcWrite;
    end
  end

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    assign phase[i] = (phaseCnt == PH_W'(i));
  end

  // R1: exactly one phase active
  a_r1_phase_onehot: assert property (@(posedge clk) disable iff (!mclrN)
    $countones(phase) == 1);
  // R1: last phase is followed by the first
  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!mclrN)
    phase[PHASES-1] |=> phase[0]);
  // R3: valid flag only moves at a cycle boundary
  a_r3_valid_hold: assert property (@(posedge clk) disable iff (!mclrN)
    !phase[PHASES-1] |=> $stable(execValid));
endmodule

// File: rtl/fseq_dp.sv
module fseq_dp
  import fseq_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int INSN_W      = 14,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              mclrN,
  input  seqCtl_t           ctl,
  input  logic [PC_W-1:0]   brTarget,
  input  logic [INSN_W-1:0] pmData,
  output logic [PC_W-1:0]   pmAddr,
  output logic [INSN_W-1:0] instrReg
);
  // Depth must be a power of two so the pointer wraps naturally
  localparam int SP_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [INSN_W-1:0] NOP_WORD = '0;

  logic [PC_W-1:0]   pc;
  logic [INSN_W-1:0] ir;
  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   spDown;
  logic [PC_W-1:0]   retStack [STACK_DEPTH];

  assign spDown = sp - SP_W'(1);

  always_ff @(posedge clk or negedge mclrN) begin
    if (!mclrN) begin
      pc <= '0;
      ir <= NOP_WORD;
      sp <= '0;
    end else if (ctl.doRet) begin
      pc <= retStack[spDown];
      sp <= spDown;
      ir <= NOP_WORD;
    end else if (ctl.doCall) begin
      pc <= brTarget;
      sp <= sp + SP_W'(1);
      ir <= NOP_WORD;
    end else if (ctl.doBranch) begin
      pc <= brTarget;
      ir <= NOP_WORD;
    end else if (ctl.advance) begin
      pc <= pc + PC_W'(1);
      ir <= pmData;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.doCall) retStack[sp] <= pc;
  end

  assign pmAddr   = pc;
  assign instrReg = ir;

  // R3: PC and IR frozen inside the cycle
  a_r3_hold: assert property (@(posedge clk) disable iff (!mclrN)
    !ctl.cycEnd |=> $stable(pc) && $stable(ir));
  // R3: sequential step
  a_r3_step: assert property (@(posedge clk) disable iff (!mclrN)
    ctl.advance |=> pc == $past(pc) + PC_W'(1));
  // R4: every PC write leaves a no-operation behind
  a_r4_flush_nop: assert property (@(posedge clk) disable iff (!mclrN)
    (ctl.doBranch || ctl.doCall || ctl.doRet) |=> ir == NOP_WORD);
  // R4: branch lands on target
  a_r4_target: assert property (@(posedge clk) disable iff (!mclrN)
    (ctl.doBranch || ctl.doCall) |=> pc == $past(brTarget));
  // R10: push moves pointer up with wrap
  a_r10_push_wrap: assert property (@(posedge clk) disable iff (!mclrN)
    ctl.doCall |=> sp == $past(sp) + SP_W'(1));
  // R6: pop moves pointer down with wrap
  a_r6_pop: assert property (@(posedge clk) disable iff (!mclrN)
    ctl.doRet |=> sp == $past(sp) - SP_W'(1));
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fseq_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int INSN_W      = 14,
  parameter int STACK_DEPTH = 8,
  parameter int PHASES      = 4
) (
  input  logic              clk,
  input  logic              mclrN,
  input  logic              brStrobe,
  input  logic              callStrobe,
  input  logic              retStrobe,
  input  logic [PC_W-1:0]   brTarget,
  input  logic [INSN_W-1:0] pmData,
  output logic [PC_W-1:0]   pmAddr,
  output logic [INSN_W-1:0] instrReg,
  output logic [PHASES-1:0] phase,
  output logic              execValid
);
  seqCtl_t ctl;

  fseq_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk(clk), .mclrN(mclrN),
    .brStrobe(brStrobe), .callStrobe(callStrobe), .retStrobe(retStrobe),
    .ctl(ctl), .phase(phase), .execValid(execValid)
  );

  fseq_dp #(.PC_W(PC_W), .INSN_W(INSN_W), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .mclrN(mclrN), .ctl(ctl),
    .brTarget(brTarget), .pmData(pmData),
    .pmAddr(pmAddr), .instrReg(instrReg)
  );
endmodule

// File: tb/sim_fetch_seq.sv
module sim_fetch_seq;
  localparam int PC_W = 13, INSN_W = 14, DEPTH = 4, PHASES = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              mclrN = 1'b0;
  logic              brStrobe = 1'b0, callStrobe = 1'b0, retStrobe = 1'b0;
  logic [PC_W-1:0]   brTarget = '0;
  logic [INSN_W-1:0] pmData;
  logic [PC_W-1:0]   pmAddr;
  logic [INSN_W-1:0] instrReg;
  logic [PHASES-1:0] phase;
  logic              execValid;

  fetch_seq #(.PC_W(PC_W), .INSN_W(INSN_W), .STACK_DEPTH(DEPTH), .PHASES(PHASES)) u0 (
    .clk(clk), .mclrN(mclrN), .brStrobe(brStrobe), .callStrobe(callStrobe),
    .retStrobe(retStrobe), .brTarget(brTarget), .pmData(pmData),
    .pmAddr(pmAddr), .instrReg(instrReg), .phase(phase), .execValid(execValid)
  );

  function automatic logic [INSN_W-1:0] memWord(input logic [PC_W-1:0] a);
    return {a[6:0], a[12:6]} ^ 14'h2A5A;
  endfunction
  assign pmData = memWord(pmAddr);

  typedef struct {
    logic [PC_W-1:0]   addr;
    logic [INSN_W-1:0] ir;
    logic              v;
    string             tag;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;

  // reference state
  logic [PC_W-1:0]   mPc = '0;
  logic [INSN_W-1:0] mIr = '0;
  logic              mValid = 1'b0;
  logic [PC_W-1:0]   mStk [DEPTH];
  int                mSp = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(input logic br, input logic call, input logic ret,
                           input logic [PC_W-1:0] tgt, input string tag);
    exp_t e;
    if (mValid && ret) begin
      mSp = (mSp + DEPTH - 1) % DEPTH;
      mPc = mStk[mSp]; mIr = '0; mValid = 1'b0;
    end else if (mValid && call) begin
      mStk[mSp] = mPc; mSp = (mSp + 1) % DEPTH;
      mPc = tgt; mIr = '0; mValid = 1'b0;
    end else if (mValid && br) begin
      mPc = tgt; mIr = '0; mValid = 1'b0;
    end else begin
      mIr = memWord(mPc); mPc = mPc + 1'b1; mValid = 1'b1;
    end
    e.addr = mPc; e.ir = mIr; e.v = mValid; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: one instruction cycle per call
  task automatic runCycle(input logic br, input logic call, input logic ret,
                          input logic [PC_W-1:0] tgt, input bit early, input string tag);
    @(negedge clk);
    while (!phase[0]) @(negedge clk);
    brStrobe = br; callStrobe = call; retStrobe = ret; brTarget = tgt;
    if (early) begin
      // R9: pulse gone before the last phase
      modelStep(1'b0, 1'b0, 1'b0, tgt, tag);
      repeat (2) @(negedge clk);
      brStrobe = 1'b0; callStrobe = 1'b0; retStrobe = 1'b0;
    end else begin
      modelStep(br, call, ret, tgt, tag);
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic normal(input string tag);
    runCycle(1'b0, 1'b0, 1'b0, '0, 1'b0, tag);
  endtask

  // monitor: compare at each cycle boundary
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mclrN && phase[0] && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " pmAddr"}, 32'(pmAddr), 32'(e.addr));
        check({e.tag, " instrReg"}, 32'(instrReg), 32'(e.ir));
        check({e.tag, " execValid"}, 32'(execValid), 32'(e.v));
      end
    end
  end

  // R1: phase rotation checker
  task automatic phaseWatch();
    logic [PHASES-1:0] expPh;
    expPh = 4'b0010;
    forever begin
      @(negedge clk);
      #1;
      check("R1 phase", 32'(phase), 32'(expPh));
      expPh = {expPh[PHASES-2:0], expPh[PHASES-1]};
    end
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R2: values under reset
    check("R2 pmAddr", 32'(pmAddr), 32'd0);
    check("R2 instrReg", 32'(instrReg), 32'd0);
    check("R2 execValid", 32'(execValid), 32'd0);
    check("R2 phase", 32'(phase), 32'h1);
    @(negedge clk);
    mclrN = 1'b1;
    #1;
    check("R2 phase after release", 32'(phase), 32'h1);
    fork phaseWatch(); join_none
    modelStep(1'b0, 1'b0, 1'b0, '0, "R3 first fetch");

    normal("R3"); normal("R3"); normal("R3");
    runCycle(1'b1, 1'b0, 1'b0, 13'd100, 1'b0, "R4 branch");
    runCycle(1'b1, 1'b0, 1'b0, 13'd200, 1'b0, "R8 strobe in bubble");
    normal("R4 after bubble"); normal("R3");
    runCycle(1'b0, 1'b1, 1'b0, 13'd300, 1'b0, "R5 call");
    normal("R5"); normal("R5");
    runCycle(1'b0, 1'b0, 1'b1, 13'd0, 1'b0, "R6 return");
    normal("R6"); normal("R6");
    runCycle(1'b1, 1'b0, 1'b0, 13'd700, 1'b1, "R9 early pulse");
    normal("R9");
    runCycle(1'b0, 1'b1, 1'b0, 13'd400, 1'b0, "R5 call");
    normal("R5");
    runCycle(1'b1, 1'b1, 1'b1, 13'd50, 1'b0, "R7 all strobes");
    normal("R7");
    runCycle(1'b1, 1'b1, 1'b0, 13'd60, 1'b0, "R7 call over branch");
    normal("R7");
    runCycle(1'b0, 1'b0, 1'b1, 13'd0, 1'b0, "R6 return");
    normal("R6");
    for (int i = 0; i <= DEPTH; i++) begin
      runCycle(1'b0, 1'b1, 1'b0, 13'(1000 + i * 16), 1'b0, "R10 push");
      normal("R10");
    end
    for (int i = 0; i <= DEPTH; i++) begin
      runCycle(1'b0, 1'b0, 1'b1, 13'd0, 1'b0, "R10 pop");
      normal("R10");
    end
    @(negedge clk);
    while (!phase[0]) @(negedge clk);
    brStrobe = 1'b0; callStrobe = 1'b0; retStrobe = 1'b0;
    repeat (8) @(negedge clk);
    check("R3 queue drained", 32'(q.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule